// File: doc/BRIEF.md
# Framed Packet Receiver with Resynchronisation

This block sits behind a byte-wide receive path, such as the receive side of a serial peripheral slave. It turns the raw byte stream into checked frames. Each frame is 58 bytes long:

- two start bytes, 0xAA then 0x55;
- a sequence byte;
- a length byte;
- a 52-byte payload;
- a 16-bit CRC.

While it has no alignment, the receiver searches the stream byte by byte for the start pair. Filler bytes and noise are skipped. Once a start pair is found, the receiver reads the rest of the frame, checks the length field and the CRC, and tracks the sequence number. A frame that passes is presented as one wide payload word with a one-cycle valid pulse.

After a frame has been read, the receiver stays locked to the 58-byte grid. It takes the next byte as the start of the next frame, without searching. A corrupted frame raises an error pulse and is not delivered. Three corrupted frames in a row, or one bad length field, show that the alignment has been lost. The receiver then drops back to searching. This recovers from byte slips and from filler flushes sent by the transmitter.

Top module: `frame_rx`

## Requirements
- R1: While searching (`hunting` high), every byte other than a 0xAA followed directly by 0x55 is skipped, including runs of 0xFF filler and a 0xAA followed by some other byte. A frame begins at the byte after the 0x55.
- R2: When the byte after a candidate 0xAA is itself 0xAA, that byte becomes the new candidate start, so the stream 0xAA 0xAA 0x55 opens a frame.
- R3: A length byte other than 52 raises `len_err` for one cycle, in the cycle after that byte. The receiver returns to searching (`hunting` high) and no frame is delivered.
- R4: The CRC is computed over the sequence, length and payload bytes. It uses polynomial 0x1021 with initial value 0xFFFF, and it is sent high byte first. On a match, `frame_valid` pulses in the cycle after the low CRC byte, together with the new `payload` and `frame_seq`. Payload byte k (k = 0 first received) appears at bits [415-8k -: 8].
- R5: On a CRC mismatch, `crc_err` pulses in the cycle after the low CRC byte. In that case `frame_valid` stays low and `payload` and `frame_seq` keep the values of the last good frame.
- R6: A good frame whose sequence byte differs from the last good sequence plus one (modulo 256) raises `seq_gap` in the same cycle as its `frame_valid`. Corrupted frames do not change the expected sequence.
- R7: The first good frame after reset, and the first good frame after a return to searching, never raise `seq_gap`.
- R8: While locked, the frame slot starts at the byte after the previous frame's CRC, and the two start bytes are not checked. A good frame clears the run of failures. The third corrupted frame in a row sends the receiver back to searching.
- R9: Bytes presented while `in_valid` is low are ignored and do not advance the frame.
- R10: After reset, all pulse outputs are low, `payload` and `frame_seq` are zero, and `hunting` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_byte` for this cycle |
| in_byte | input | 8 | Received stream byte |
| frame_valid | output | 1 | One-cycle pulse: a checked frame is on `payload` |
| payload | output | 416 | Payload of the last good frame, first byte in the top bits |
| frame_seq | output | 8 | Sequence byte of the last good frame |
| crc_err | output | 1 | One-cycle pulse: frame failed its CRC |
| len_err | output | 1 | One-cycle pulse: length field was not 52 |
| seq_gap | output | 1 | One-cycle pulse with `frame_valid`: frames were missed |
| hunting | output | 1 | High while searching for the start pair |

## Verification
The hardest situation to reach from the ports is the locked state while failures are building up. After one or two corrupted frames the receiver must still be on the grid. The third consecutive failure must drop it back to searching, and only then may the sequence expectation be forgotten.

The stimulus builds a clean lock with the vector table, then sends corrupted frames back to back. It checks `hunting` after each one. A following frame with its start bytes blanked to 0x00 then confirms that slot alignment, and not a search, is what places a locked frame.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    localparam logic [7:0]  SYNC_A    = 8'hAA;
    localparam logic [7:0]  SYNC_B    = 8'h55;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;

    typedef enum logic [3:0] {
        ST_SEARCH,
        ST_SYNC2,
        ST_SLOT0,
        ST_SLOT1,
        ST_SEQ,
        ST_LEN,
        ST_BODY,
        ST_CHK_HI,
        ST_CHK_LO
    } rx_state_e;

    typedef struct packed {
        logic good;
        logic bad_crc;
        logic bad_len;
        logic gap;
    } rx_flags_t;

    // One byte of CRC-16 (poly 0x1021), MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/frame_rx_crc.sv
module frame_rx_crc
    import frame_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc16_byte(crc, din);
        end
    end
endmodule

// File: rtl/frame_rx_seq.sv
module frame_rx_seq (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] seq_in,
    output logic       gap
);
    logic       have_q;
    logic [7:0] next_q;

    assign gap = have_q && (seq_in != next_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_q <= 1'b0;
            next_q <= 8'h00;
        end else if (upd) begin
            have_q <= 1'b1;
            next_q <= seq_in + 8'd1;
        end
    end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import frame_rx_pkg::*;
#(
    parameter int PAYLOAD_LEN = 52,
    parameter int FAIL_LIMIT  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [7:0]               in_byte,
    output logic                     frame_valid,
    output logic [PAYLOAD_LEN*8-1:0] payload,
    output logic [7:0]               frame_seq,
    output logic                     crc_err,
    output logic                     len_err,
    output logic                     seq_gap,
    output logic                     hunting
);
    localparam int         PW       = PAYLOAD_LEN * 8;
    localparam int         CW       = $clog2(PAYLOAD_LEN);
    localparam int         FW       = $clog2(FAIL_LIMIT + 1);
    localparam logic [7:0] LEN_CODE = 8'(PAYLOAD_LEN);

    rx_state_e      st_q, st_d;
    logic [FW-1:0]  fail_q, fail_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [7:0]     seq_q, crc_hi_q;
    logic [PW-1:0]  body_q, payload_q;
    logic [7:0]     fseq_q;
    rx_flags_t      flg_q, flg_d;

    logic           crc_clr, crc_en, seq_clr, seq_upd;
    logic           take_seq, take_body, take_hi;
    logic [15:0]    crc_q;
    logic           gap_w, crc_match;

    frame_rx_crc u_crc (
        .clk (clk), .rst (rst), .clr (crc_clr), .en (crc_en),
        .din (in_byte), .crc (crc_q)
    );

    frame_rx_seq u_seq (
        .clk (clk), .rst (rst), .clr (seq_clr), .upd (seq_upd),
        .seq_in (seq_q), .gap (gap_w)
    );

    assign crc_match = ({crc_hi_q, in_byte} == crc_q);

    always_comb begin
        st_d      = st_q;
        fail_d    = fail_q;
        cnt_d     = cnt_q;
        flg_d     = '0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        seq_clr   = 1'b0;
        seq_upd   = 1'b0;
        take_seq  = 1'b0;
        take_body = 1'b0;
        take_hi   = 1'b0;
        if (in_valid) begin
            case (st_q)
                ST_SEARCH: if (in_byte == SYNC_A) st_d = ST_SYNC2;
                ST_SYNC2: begin
                    if (in_byte == SYNC_B) begin
                        st_d    = ST_SEQ;
                        crc_clr = 1'b1;
                    end else if (in_byte != SYNC_A) begin
                        st_d = ST_SEARCH;
                    end
                end
                ST_SLOT0: st_d = ST_SLOT1;
                ST_SLOT1: begin
                    st_d    = ST_SEQ;
                    crc_clr = 1'b1;
                end
                ST_SEQ: begin
                    crc_en   = 1'b1;
                    take_seq = 1'b1;
                    st_d     = ST_LEN;
                end
                ST_LEN: begin
                    if (in_byte == LEN_CODE) begin
                        crc_en = 1'b1;
                        cnt_d  = '0;
                        st_d   = ST_BODY;
                    end else begin
                        flg_d.bad_len = 1'b1;
                        fail_d        = '0;
                        seq_clr       = 1'b1;
                        st_d          = ST_SEARCH;
                    end
                end
                ST_BODY: begin
                    crc_en    = 1'b1;
                    take_body = 1'b1;
                    if (cnt_q == CW'(PAYLOAD_LEN - 1)) st_d = ST_CHK_HI;
                    else cnt_d = cnt_q + 1'b1;
                end
                ST_CHK_HI: begin
                    take_hi = 1'b1;
                    st_d    = ST_CHK_LO;
                end
                ST_CHK_LO: begin
                    if (crc_match) begin
                        flg_d.good = 1'b1;
                        flg_d.gap  = gap_w;
                        seq_upd    = 1'b1;
                        fail_d     = '0;
                        st_d       = ST_SLOT0;
                    end else begin
                        flg_d.bad_crc = 1'b1;
                        if (fail_q == FW'(FAIL_LIMIT - 1)) begin
                            fail_d  = '0;
                            seq_clr = 1'b1;
                            st_d    = ST_SEARCH;
                        end else begin
                            fail_d = fail_q + 1'b1;
                            st_d   = ST_SLOT0;
                        end
                    end
                end
                default: st_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_SEARCH;
            fail_q    <= '0;
            cnt_q     <= '0;
            seq_q     <= '0;
            crc_hi_q  <= '0;
            body_q    <= '0;
            payload_q <= '0;
            fseq_q    <= '0;
            flg_q     <= '0;
        end else begin
            st_q   <= st_d;
            fail_q <= fail_d;
            cnt_q  <= cnt_d;
            flg_q  <= flg_d;
            if (take_seq)  seq_q    <= in_byte;
            if (take_hi)   crc_hi_q <= in_byte;
            if (take_body) body_q   <= {body_q[PW-9:0], in_byte};
            if (flg_d.good) begin
                payload_q <= body_q;
                fseq_q    <= seq_q;
            end
        end
    end

    assign frame_valid = flg_q.good;
    assign crc_err     = flg_q.bad_crc;
    assign len_err     = flg_q.bad_len;
    assign seq_gap     = flg_q.gap;
    assign payload     = payload_q;
    assign frame_seq   = fseq_q;
    assign hunting     = (st_q == ST_SEARCH) || (st_q == ST_SYNC2);

endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
    parameter int PAYLOAD_LEN = 52
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     frame_valid,
    input logic [PAYLOAD_LEN*8-1:0] payload,
    input logic                     crc_err,
    input logic                     len_err,
    input logic                     seq_gap,
    input logic                     hunting
);
    // R4 R5: a frame ends in at most one verdict
    assert_one_verdict_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_valid, crc_err, len_err}));

    // R6: a gap is only reported alongside a delivered frame
    assert_gap_with_frame_R6: assert property (@(posedge clk) disable iff (rst)
        seq_gap |-> frame_valid);

    // R5: the payload only changes on delivery
    assert_payload_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> $stable(payload));

    // R3: a bad length leaves the receiver searching
    assert_len_err_hunts_R3: assert property (@(posedge clk) disable iff (rst)
        len_err |-> hunting);

    // R8: a delivered frame leaves the receiver locked
    assert_good_locks_R8: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> !hunting);

    // R9: every verdict follows a qualified byte
    assert_verdict_needs_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_valid || crc_err || len_err) |-> $past(in_valid));
endmodule

bind frame_rx frame_rx_chk #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .frame_valid (frame_valid),
    .payload     (payload),
    .crc_err     (crc_err),
    .len_err     (len_err),
    .seq_gap     (seq_gap),
    .hunting     (hunting)
);

// File: tb/tb_frame_rx.sv
module tb_frame_rx;
    localparam int PL = 52;
    localparam int PW = PL * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          frame_valid, crc_err, len_err, seq_gap, hunting;
    logic [PW-1:0] payload;
    logic [7:0]    frame_seq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [PW-1:0] exp_pay;
    logic [PW-1:0] last_pay = '0;
    logic [7:0]    last_seq = 8'h00;

    always #2 clk = ~clk;

    frame_rx dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_byte (in_byte),
        .frame_valid (frame_valid), .payload (payload), .frame_seq (frame_seq),
        .crc_err (crc_err), .len_err (len_err), .seq_gap (seq_gap),
        .hunting (hunting)
    );

    // {fill count, seq, seed, flags}; flags bit2 corrupt, bit1 deliver, bit0 gap
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {8'd10, 8'd5,   8'h11, 8'h02},
        {8'd0,  8'd6,   8'h22, 8'h02},
        {8'd0,  8'd8,   8'h33, 8'h03},
        {8'd0,  8'd9,   8'h44, 8'h04},
        {8'd0,  8'd9,   8'h55, 8'h02},
        {8'd0,  8'd255, 8'h66, 8'h03},
        {8'd0,  8'd0,   8'h77, 8'h02}
    };

    task automatic check(input string what, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bitwise(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic send_byte(input logic [7:0] b, input int idle);
        for (int i = 0; i < idle; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hAA;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic send_frame(input logic [7:0] seq, input logic [7:0] seed,
                              input bit corrupt, input bit real_sync, input int idle);
        logic [15:0] c = 16'hFFFF;
        logic [7:0]  b;
        exp_pay = '0;
        send_byte(real_sync ? 8'hAA : 8'h00, idle);
        send_byte(real_sync ? 8'h55 : 8'h00, idle);
        send_byte(seq, idle);         c = crc_bitwise(c, seq);
        send_byte(8'd52, idle);       c = crc_bitwise(c, 8'd52);
        for (int k = 0; k < PL; k++) begin
            b = seed + 8'(k * 29);
            exp_pay = {exp_pay[PW-9:0], b};
            send_byte(b, idle);
            c = crc_bitwise(c, b);
        end
        if (corrupt) c = c ^ 16'h0100;
        send_byte(c[15:8], idle);
        send_byte(c[7:0], idle);
    endtask

    task automatic expect_frame(input string tag, input logic [7:0] seq, input bit gap);
        check({tag, " frame_valid"}, PW'(frame_valid), PW'(1));
        check({tag, " crc_err"},     PW'(crc_err),     PW'(0));
        check({tag, " seq_gap"},     PW'(seq_gap),     PW'(gap));
        check({tag, " payload"},     payload,          exp_pay);
        check({tag, " frame_seq"},   PW'(frame_seq),   PW'(seq));
        last_pay = exp_pay;
        last_seq = seq;
    endtask

    task automatic expect_reject(input string tag);
        check({tag, " crc_err"},     PW'(crc_err),     PW'(1));
        check({tag, " frame_valid"}, PW'(frame_valid), PW'(0));
        check({tag, " payload held"}, payload,         last_pay);
        check({tag, " seq held"},    PW'(frame_seq),   PW'(last_seq));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10 frame_valid", PW'(frame_valid), PW'(0));
        check("R10 pulses", PW'({crc_err, len_err, seq_gap}), PW'(0));
        check("R10 payload", payload, '0);
        check("R10 frame_seq", PW'(frame_seq), PW'(0));
        check("R10 hunting", PW'(hunting), PW'(1));

        // Table: R1 filler skip, R4 delivery, R5 reject, R6 gap and wrap, R7 first frame
        for (int v = 0; v < NV; v++) begin
            logic [7:0] fill = VEC[v][31:24];
            logic [7:0] sq   = VEC[v][23:16];
            logic [7:0] sd   = VEC[v][15:8];
            logic [7:0] fl   = VEC[v][7:0];
            for (int f = 0; f < int'(fill); f++) send_byte(8'hFF, 0);
            send_frame(sq, sd, fl[2], 1'b1, 0);
            settle();
            check($sformatf("R3 vec%0d len_err", v), PW'(len_err), PW'(0));
            if (fl[1]) expect_frame($sformatf("R4 R6 R7 vec%0d", v), sq, fl[0]);
            else       expect_reject($sformatf("R5 vec%0d", v));
        end

        // R8: failures build up while locked; third one returns to search
        send_frame(8'd1, 8'h80, 1'b1, 1'b1, 0);
        settle();
        expect_reject("R5 fail1");
        check("R8 locked after fail1", PW'(hunting), PW'(0));
        send_frame(8'd1, 8'h81, 1'b1, 1'b1, 0);
        settle();
        expect_reject("R5 fail2");
        check("R8 locked after fail2", PW'(hunting), PW'(0));
        send_frame(8'd1, 8'h82, 1'b1, 1'b1, 0);
        settle();
        expect_reject("R5 fail3");
        check("R8 search after fail3", PW'(hunting), PW'(1));

        // R2: 0xAA 0xAA 0x55 restarts the candidate; R7: no gap after resync
        send_byte(8'h12, 0);
        send_byte(8'hAA, 0);
        send_frame(8'h30, 8'h90, 1'b0, 1'b1, 0);
        settle();
        expect_frame("R2 R7 double sync", 8'h30, 1'b0);

        // R3: a bad length field while locked
        send_byte(8'hAA, 0);
        send_byte(8'h55, 0);
        send_byte(8'h31, 0);
        send_byte(8'd51, 0);
        settle();
        check("R3 len_err", PW'(len_err), PW'(1));
        check("R3 hunting", PW'(hunting), PW'(1));
        check("R3 no frame", PW'(frame_valid), PW'(0));

        // R1: filler and an 0xAA not followed by 0x55 are skipped; R7 after resync
        send_byte(8'hFF, 0);
        send_byte(8'hAA, 0);
        send_byte(8'h13, 0);
        send_byte(8'hFF, 0);
        send_frame(8'h50, 8'hA0, 1'b0, 1'b1, 0);
        settle();
        expect_frame("R1 R7 resync", 8'h50, 1'b0);

        // R9: idle cycles carrying junk between every byte
        send_frame(8'h51, 8'hB0, 1'b0, 1'b1, 1);
        settle();
        expect_frame("R9 idle gaps", 8'h51, 1'b0);

        // R8: locked slot accepted without a sync pair
        send_frame(8'h52, 8'hC0, 1'b0, 1'b0, 0);
        settle();
        expect_frame("R8 slot position", 8'h52, 1'b0);
        check("R8 still locked", PW'(hunting), PW'(0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule